// File: doc/BRIEF.md
# Adapter Host Glue Register Block

This block is the host-side glue between an 8-bit host I/O window and a network controller's register port. The window is split into two regions. The low eight offsets are a data region. Three offsets above it hold the glue's own control registers. Depending on a map bit, the data region reaches either the controller's registers or a read-only identification overlay of two pages. The overlay returns a fixed manufacturer code, a card type, a revision, three strapped configuration bytes and a six-byte station address.

The controller's register select is two bits wide, plus a byte-lane bit. The glue adds a third select bit, the register-bank bit, so a driver can reach the controller's upper eight byte registers through the same eight window offsets. The glue also drives the controller's active-low reset, the line-rate select and the cable-type select.

Controller interrupts go into a latch that the control logic maintains as a three-state machine. The states are `LAT_CLEAR`, `LAT_SET` and `LAT_DISARMED`, and the transitions are:
- *arm*: CLEAR→SET on an interrupt rising edge.
- *disarm*: SET→DISARMED on a write that turns the enable bit off, with no edge in that cycle.
- *re-hit*: DISARMED→SET on an edge.
- *rearm*: DISARMED→CLEAR on a write that turns the enable bit back on, with no edge in that cycle.

The host interrupt is a level signal. It is high while the latch is set and the enable bit is on.

Top module: `adapter_host_glue`

## Requirements
- R1: After reset every control bit is 0. Register 0 (offset 8) reads 0x00 and register 1 (offset 9) reads 0x00. `ctl_rst_n`, `host_irq`, `speed_hi` and `cable_utp` are all 0, so the overlay is mapped and the controller is held in reset.
- R2: While register 0 bit 2 is 0 and bit 3 is 0, data-region reads at offsets 0 to 7 return the following bytes:
  - offset 0: the manufacturer code 0x4D;
  - offset 1: the card type;
  - offset 2: `id_rev`;
  - offsets 3 to 5: the three `id_cfg` bytes, most significant first;
  - offsets 6 and 7: 0x00.
- R3: While register 0 bit 2 is 0 and bit 3 is 1, offset 0 reads 0x00, offsets 1 to 6 return the `id_stn` bytes most significant first, and offset 7 reads 0x00.
- R4: While register 0 bit 2 is 1, data-region accesses go to the controller:
  - a read pulses `ctl_rd` and returns `ctl_rdata`;
  - a write pulses `ctl_wr` with `ctl_wdata` equal to the host data;
  - `ctl_lane` is offset bit 0.
- R5: While register 0 bit 2 is 0, `ctl_rd` and `ctl_wr` stay 0 for data-region accesses, and reads return overlay bytes, not `ctl_rdata`.
- R6: `ctl_rs` is {register 1 bit 2, offset bits 2:1}, so setting bit 2 reaches controller registers 8 to 15.
- R7: `ctl_rst_n` follows register 1 bit 0. Writing 0x00 to register 1 holds the controller in reset.
- R8: `speed_hi` follows register 1 bit 3 (1 = high ring rate).
- R9: Offset 15 is write-only. Its bit 0 drives `cable_utp` (1 = unshielded pair), and reads of offset 15 return 0x00.
- R10: A rising edge on `ctl_irq` sets the latch at that clock edge. Register 0 bit 0 reads 1 while the latch is set, and the latch stays set after `ctl_irq` falls.
- R11: `host_irq` is 1 exactly while the latch is set and register 1 bit 1 (interrupt enable) is 1.
- R12: The latch clears only when a write turning bit 1 of register 1 off is followed by a write turning it on. An interrupt edge in the cycle of either write, or between them, keeps the latch set. Turning the enable on without first turning it off does not clear the latch.
- R13: Register 0 reads back bits 3:2 as written, with the status in bit 0 and zeros elsewhere. Register 1 reads back bits 3:0 as written, with zeros above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hst_addr | input | ADDR_W | Host window offset |
| hst_rd | input | 1 | Host read strobe, one cycle |
| hst_wr | input | 1 | Host write strobe, one cycle |
| hst_wdata | input | 8 | Host write data |
| hst_rdata | output | 8 | Host read data, combinational |
| host_irq | output | 1 | Level host interrupt |
| ctl_rd | output | 1 | Controller register read strobe |
| ctl_wr | output | 1 | Controller register write strobe |
| ctl_rs | output | 3 | Controller register select, bank bit on top |
| ctl_lane | output | 1 | Controller byte lane |
| ctl_wdata | output | 8 | Controller write data |
| ctl_rdata | input | 8 | Controller read data |
| ctl_irq | input | 1 | Controller interrupt request |
| ctl_rst_n | output | 1 | Controller reset, active low |
| speed_hi | output | 1 | Line-rate select |
| cable_utp | output | 1 | Cable-type select |
| id_rev | input | 8 | Strapped revision byte |
| id_cfg | input | CFG_N*8 | Strapped configuration bytes |
| id_stn | input | STN_N*8 | Strapped station address |

## Verification
The assertions assume the following about the inputs:
- `hst_rd` and `hst_wr` are never high in the same cycle.
- `ctl_irq` is low while reset is applied, so no edge can be taken from the reset value of the edge detector.
- The strap inputs hold still.

The stimulus drives every host strobe for exactly one cycle, changing it on the falling clock edge. It holds `ctl_irq` low through both resets. Edges on `ctl_irq` are made as one-cycle high pulses placed in known relation to the enable writes, including one pulse that coincides with the re-enable write.

// File: rtl/hg_pkg.sv
package hg_pkg;
    localparam int BYTE_W    = 8;
    localparam int WIN_W     = 3;
    localparam int WIN_SLOTS = 1 << WIN_W;

    // register 0 bit positions
    localparam int C0_STAT = 0;
    localparam int C0_MAP  = 2;
    localparam int C0_PAGE = 3;

    // register 1 bit positions
    localparam int C1_NRST  = 0;
    localparam int C1_IEN   = 1;
    localparam int C1_BANK  = 2;
    localparam int C1_SPEED = 3;

    typedef enum logic [1:0] {
        LAT_CLEAR    = 2'd0,
        LAT_SET      = 2'd1,
        LAT_DISARMED = 2'd2
    } lat_state_e;
endpackage

// File: rtl/hg_ctrl_regs.sv
module hg_ctrl_regs
    import hg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_c0,
    input  logic       wr_c1,
    input  logic       wr_cab,
    input  logic [3:0] wdata,
    output logic       map_ctl,
    output logic       rom_page,
    output logic       nrst,
    output logic       ien,
    output logic       bank,
    output logic       speed,
    output logic       cable,
    output logic       ien_fall,
    output logic       ien_rise
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            map_ctl  <= 1'b0;
            rom_page <= 1'b0;
            nrst     <= 1'b0;
            ien      <= 1'b0;
            bank     <= 1'b0;
            speed    <= 1'b0;
            cable    <= 1'b0;
        end else begin
            if (wr_c0) begin
                map_ctl  <= wdata[C0_MAP];
                rom_page <= wdata[C0_PAGE];
            end
            if (wr_c1) begin
                nrst  <= wdata[C1_NRST];
                ien   <= wdata[C1_IEN];
                bank  <= wdata[C1_BANK];
                speed <= wdata[C1_SPEED];
            end
            if (wr_cab) begin
                cable <= wdata[0];
            end
        end
    end

    // enable-bit transitions seen by the interrupt latch
    always_comb begin
        ien_fall = wr_c1 &&  ien && !wdata[C1_IEN];
        ien_rise = wr_c1 && !ien &&  wdata[C1_IEN];
    end

    AST_RESET_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (wr_c1 && !wdata[C1_NRST]) |=> !nrst); // R7
    AST_SPEED_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) wr_c1 |=> (speed == $past(wdata[C1_SPEED]))); // R8
endmodule

// File: rtl/hg_irq_latch.sv
module hg_irq_latch
    import hg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic irq_in,
    input  logic ien,
    input  logic ien_fall,
    input  logic ien_rise,
    output logic latched,
    output logic host_irq
);
    logic       irq_q;
    logic       rise;
    lat_state_e st;
    lat_state_e st_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= irq_in;
    end

    assign rise = irq_in && !irq_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= LAT_CLEAR;
        else        st <= st_nx;
    end

    // transitions: arm, disarm, re-hit, rearm
    always_comb begin
        st_nx = st;
        unique case (st)
            LAT_CLEAR: begin
                if (rise) st_nx = LAT_SET;
            end
            LAT_SET: begin
                if (ien_fall && !rise) st_nx = LAT_DISARMED;
            end
            LAT_DISARMED: begin
                if (rise)          st_nx = LAT_SET;
                else if (ien_rise) st_nx = LAT_CLEAR;
            end
            default: st_nx = LAT_CLEAR;
        endcase
    end

    // outputs
    always_comb begin
        latched  = (st != LAT_CLEAR);
        host_irq = latched && ien;
    end

    AST_EDGE_SETS: assert property (@(posedge clk) disable iff (!rst_n) $rose(irq_in) |=> latched); // R10
    AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (latched && !ien_rise) |=> latched); // R12
    AST_REARM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (st == LAT_DISARMED && ien_rise && !rise) |=> !latched); // R12
endmodule

// File: rtl/hg_id_rom.sv
module hg_id_rom
    import hg_pkg::*;
#(
    parameter logic [7:0] MANUF_ID  = 8'h4D,
    parameter logic [7:0] CARD_TYPE = 8'h08,
    parameter int         CFG_N     = 3,
    parameter int         STN_N     = 6
) (
    input  logic                      page,
    input  logic [WIN_W-1:0]          ofs,
    input  logic [BYTE_W-1:0]         rev,
    input  logic [CFG_N*BYTE_W-1:0]   cfg,
    input  logic [STN_N*BYTE_W-1:0]   stn,
    output logic [BYTE_W-1:0]         byte_o
);
    logic [BYTE_W-1:0] pg0 [WIN_SLOTS];
    logic [BYTE_W-1:0] pg1 [WIN_SLOTS];

    for (genvar i = 0; i < WIN_SLOTS; i++) begin : g_slot
        if (i == 0) begin : g_man
            assign pg0[i] = MANUF_ID;
        end else if (i == 1) begin : g_type
            assign pg0[i] = CARD_TYPE;
        end else if (i == 2) begin : g_rev
            assign pg0[i] = rev;
        end else if (i < 3 + CFG_N) begin : g_cfg
            assign pg0[i] = cfg[(CFG_N - 1 - (i - 3)) * BYTE_W +: BYTE_W];
        end else begin : g_pad0
            assign pg0[i] = '0;
        end

        if (i >= 1 && i <= STN_N) begin : g_stn
            assign pg1[i] = stn[(STN_N - i) * BYTE_W +: BYTE_W];
        end else begin : g_pad1
            assign pg1[i] = '0;
        end
    end

    assign byte_o = page ? pg1[ofs] : pg0[ofs];
endmodule

// File: rtl/adapter_host_glue.sv
module adapter_host_glue
    import hg_pkg::*;
#(
    parameter int                ADDR_W    = 4,
    parameter logic [7:0]        MANUF_ID  = 8'h4D,
    parameter logic [7:0]        CARD_TYPE = 8'h08,
    parameter int                CFG_N     = 3,
    parameter int                STN_N     = 6,
    parameter logic [ADDR_W-1:0] CTL0_OFS  = ADDR_W'(8),
    parameter logic [ADDR_W-1:0] CTL1_OFS  = ADDR_W'(9),
    parameter logic [ADDR_W-1:0] CAB_OFS   = ADDR_W'(15)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       hst_addr,
    input  logic                    hst_rd,
    input  logic                    hst_wr,
    input  logic [7:0]              hst_wdata,
    output logic [7:0]              hst_rdata,
    output logic                    host_irq,
    output logic                    ctl_rd,
    output logic                    ctl_wr,
    output logic [2:0]              ctl_rs,
    output logic                    ctl_lane,
    output logic [7:0]              ctl_wdata,
    input  logic [7:0]              ctl_rdata,
    input  logic                    ctl_irq,
    output logic                    ctl_rst_n,
    output logic                    speed_hi,
    output logic                    cable_utp,
    input  logic [7:0]              id_rev,
    input  logic [CFG_N*8-1:0]      id_cfg,
    input  logic [STN_N*8-1:0]      id_stn
);
    logic in_win;
    logic map_ctl, rom_page, ien, bank;
    logic ien_fall, ien_rise, latched;
    logic wr_c0, wr_c1, wr_cab;
    logic [BYTE_W-1:0] rom_byte;

    assign in_win = (hst_addr[ADDR_W-1:WIN_W] == '0);
    assign wr_c0  = hst_wr && (hst_addr == CTL0_OFS);
    assign wr_c1  = hst_wr && (hst_addr == CTL1_OFS);
    assign wr_cab = hst_wr && (hst_addr == CAB_OFS);

    hg_ctrl_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_c0    (wr_c0),
        .wr_c1    (wr_c1),
        .wr_cab   (wr_cab),
        .wdata    (hst_wdata[3:0]),
        .map_ctl  (map_ctl),
        .rom_page (rom_page),
        .nrst     (ctl_rst_n),
        .ien      (ien),
        .bank     (bank),
        .speed    (speed_hi),
        .cable    (cable_utp),
        .ien_fall (ien_fall),
        .ien_rise (ien_rise)
    );

    hg_irq_latch u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .irq_in   (ctl_irq),
        .ien      (ien),
        .ien_fall (ien_fall),
        .ien_rise (ien_rise),
        .latched  (latched),
        .host_irq (host_irq)
    );

    hg_id_rom #(
        .MANUF_ID  (MANUF_ID),
        .CARD_TYPE (CARD_TYPE),
        .CFG_N     (CFG_N),
        .STN_N     (STN_N)
    ) u_rom (
        .page   (rom_page),
        .ofs    (hst_addr[WIN_W-1:0]),
        .rev    (id_rev),
        .cfg    (id_cfg),
        .stn    (id_stn),
        .byte_o (rom_byte)
    );

    // controller side: bank bit extends the two-bit select
    assign ctl_rd    = hst_rd && in_win && map_ctl;
    assign ctl_wr    = hst_wr && in_win && map_ctl;
    assign ctl_rs    = {bank, hst_addr[WIN_W-1:1]};
    assign ctl_lane  = hst_addr[0];
    assign ctl_wdata = hst_wdata;

    // host read mux
    always_comb begin
        hst_rdata = '0;
        if (in_win) begin
            hst_rdata = map_ctl ? ctl_rdata : rom_byte;
        end else if (hst_addr == CTL0_OFS) begin
            hst_rdata[C0_STAT] = latched;
            hst_rdata[C0_MAP]  = map_ctl;
            hst_rdata[C0_PAGE] = rom_page;
        end else if (hst_addr == CTL1_OFS) begin
            hst_rdata[C1_NRST]  = ctl_rst_n;
            hst_rdata[C1_IEN]   = ien;
            hst_rdata[C1_BANK]  = bank;
            hst_rdata[C1_SPEED] = speed_hi;
        end
    end

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n) host_irq |-> (ien && latched)); // R11
    AST_ROM_NO_CTL: assert property (@(posedge clk) disable iff (!rst_n) (in_win && !map_ctl) |-> (!ctl_wr && !ctl_rd)); // R5
endmodule

// File: tb/test_adapter_host_glue.sv
module test_adapter_host_glue;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  hst_addr = '0;
    logic        hst_rd = 1'b0;
    logic        hst_wr = 1'b0;
    logic [7:0]  hst_wdata = '0;
    logic [7:0]  hst_rdata;
    logic        host_irq, ctl_rd, ctl_wr, ctl_lane, ctl_rst_n, speed_hi, cable_utp;
    logic [2:0]  ctl_rs;
    logic [7:0]  ctl_wdata;
    logic [7:0]  ctl_rdata = 8'h77;
    logic        ctl_irq = 1'b0;
    logic [7:0]  id_rev = 8'h03;
    logic [23:0] id_cfg = 24'h5AC321;
    logic [47:0] id_stn = 48'h102233445566;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    adapter_host_glue i_adapter_host_glue (
        .clk(clk), .rst_n(rst_n), .hst_addr(hst_addr), .hst_rd(hst_rd), .hst_wr(hst_wr),
        .hst_wdata(hst_wdata), .hst_rdata(hst_rdata), .host_irq(host_irq),
        .ctl_rd(ctl_rd), .ctl_wr(ctl_wr), .ctl_rs(ctl_rs), .ctl_lane(ctl_lane),
        .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata), .ctl_irq(ctl_irq),
        .ctl_rst_n(ctl_rst_n), .speed_hi(speed_hi), .cable_utp(cable_utp),
        .id_rev(id_rev), .id_cfg(id_cfg), .id_stn(id_stn)
    );

    typedef struct packed {
        logic       wr;
        logic [3:0] addr;
        logic [7:0] data;   // write data, or expected read data
        logic [3:0] req;
    } vec_t;

    localparam int NV = 29;
    localparam vec_t VT [NV] = '{
        '{1'b0, 4'h8, 8'h00, 4'd1},   // R1 register 0 after reset
        '{1'b0, 4'h9, 8'h00, 4'd1},   // R1 register 1 after reset
        '{1'b0, 4'h0, 8'h4D, 4'd2},   // R2 manufacturer code
        '{1'b0, 4'h1, 8'h08, 4'd2},   // R2 card type
        '{1'b0, 4'h2, 8'h03, 4'd2},   // R2 revision
        '{1'b0, 4'h3, 8'h5A, 4'd2},   // R2 cfg byte 0
        '{1'b0, 4'h4, 8'hC3, 4'd2},   // R2 cfg byte 1
        '{1'b0, 4'h5, 8'h21, 4'd2},   // R2 cfg byte 2
        '{1'b0, 4'h6, 8'h00, 4'd2},   // R2 pad
        '{1'b0, 4'h7, 8'h00, 4'd2},   // R2 pad
        '{1'b1, 4'h8, 8'h08, 4'd3},   // R3 select page 1
        '{1'b0, 4'h8, 8'h08, 4'd13},  // R13 readback
        '{1'b0, 4'h0, 8'h00, 4'd3},   // R3 unused slot
        '{1'b0, 4'h1, 8'h10, 4'd3},   // R3 station MSB
        '{1'b0, 4'h2, 8'h22, 4'd3},
        '{1'b0, 4'h3, 8'h33, 4'd3},
        '{1'b0, 4'h4, 8'h44, 4'd3},
        '{1'b0, 4'h5, 8'h55, 4'd3},
        '{1'b0, 4'h6, 8'h66, 4'd3},   // R3 station LSB
        '{1'b0, 4'h7, 8'h00, 4'd3},
        '{1'b1, 4'hF, 8'h01, 4'd9},   // R9 cable select
        '{1'b0, 4'hF, 8'h00, 4'd9},   // R9 write-only reads zero
        '{1'b1, 4'h9, 8'h0E, 4'd13},  // enable, bank, speed; reset held
        '{1'b0, 4'h9, 8'h0E, 4'd13},  // R13 readback
        '{1'b1, 4'h8, 8'hFF, 4'd13},  // map controller, page 1
        '{1'b0, 4'h8, 8'h0C, 4'd13},  // R13 only bits 3:2 stored
        '{1'b1, 4'hA, 8'hFF, 4'd13},  // unused offset
        '{1'b0, 4'hA, 8'h00, 4'd13},  // R13 unused offset reads zero
        '{1'b0, 4'h9, 8'h0E, 4'd13}   // R13 unaffected
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        hst_addr = a; hst_wdata = d; hst_wr = 1'b1;
        @(negedge clk);
        hst_wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [3:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        hst_addr = a; hst_rd = 1'b1;
        #1;
        chk(tag, hst_rdata, exp);
        hst_rd = 1'b0;
    endtask

    task automatic pulse_irq();
        @(negedge clk);
        ctl_irq = 1'b1;
        @(negedge clk);
        ctl_irq = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset outputs
        chk("R1 ctl_rst_n", {7'b0, ctl_rst_n}, 8'h00);
        chk("R1 host_irq", {7'b0, host_irq}, 8'h00);
        chk("R1 speed_hi", {7'b0, speed_hi}, 8'h00);
        chk("R1 cable_utp", {7'b0, cable_utp}, 8'h00);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            if (VT[i].wr) bus_wr(VT[i].addr, VT[i].data);
            else bus_rd(VT[i].addr, VT[i].data, $sformatf("R%0d vec %0d", VT[i].req, i));
        end

        chk("R9 cable_utp", {7'b0, cable_utp}, 8'h01);
        chk("R8 speed_hi set", {7'b0, speed_hi}, 8'h01);
        chk("R7 reset held", {7'b0, ctl_rst_n}, 8'h00);
        bus_wr(4'h9, 8'h0F);
        chk("R7 reset released", {7'b0, ctl_rst_n}, 8'h01);

        // R4 / R6 controller write with bank set
        @(negedge clk);
        hst_addr = 4'h5; hst_wdata = 8'hA5; hst_wr = 1'b1;
        #1;
        chk("R4 ctl_wr", {7'b0, ctl_wr}, 8'h01);
        chk("R4 ctl_wdata", ctl_wdata, 8'hA5);
        chk("R6 ctl_rs bank", {5'b0, ctl_rs}, 8'h06);
        chk("R4 ctl_lane", {7'b0, ctl_lane}, 8'h01);
        hst_wr = 1'b0;
        @(negedge clk);
        hst_addr = 4'h2; hst_rd = 1'b1;
        #1;
        chk("R4 ctl_rd", {7'b0, ctl_rd}, 8'h01);
        chk("R4 read data", hst_rdata, 8'h77);
        chk("R6 ctl_rs rd", {5'b0, ctl_rs}, 8'h05);
        chk("R4 ctl_lane rd", {7'b0, ctl_lane}, 8'h00);
        hst_rd = 1'b0;

        bus_wr(4'h9, 8'h03);   // bank off, speed low, enable on
        chk("R8 speed_hi clear", {7'b0, speed_hi}, 8'h00);
        @(negedge clk);
        hst_addr = 4'h6;
        #1;
        chk("R6 ctl_rs no bank", {5'b0, ctl_rs}, 8'h03);

        // R5 overlay blocks the controller
        bus_wr(4'h8, 8'h00);
        @(negedge clk);
        hst_addr = 4'h3; hst_wdata = 8'h11; hst_wr = 1'b1;
        #1;
        chk("R5 no ctl_wr", {7'b0, ctl_wr}, 8'h00);
        hst_wr = 1'b0;
        @(negedge clk);
        hst_rd = 1'b1;
        #1;
        chk("R5 no ctl_rd", {7'b0, ctl_rd}, 8'h00);
        chk("R5 overlay data", hst_rdata, 8'h5A);
        hst_rd = 1'b0;

        // R10 / R11 / R12 interrupt latch
        pulse_irq();
        bus_rd(4'h8, 8'h01, "R10 status set");
        chk("R11 host_irq on", {7'b0, host_irq}, 8'h01);
        repeat (3) @(negedge clk);
        chk("R10 level held", {7'b0, host_irq}, 8'h01);
        bus_wr(4'h9, 8'h01);
        chk("R11 masked", {7'b0, host_irq}, 8'h00);
        bus_rd(4'h8, 8'h01, "R12 still set after disable");
        bus_wr(4'h9, 8'h03);
        bus_rd(4'h8, 8'h00, "R12 cleared by toggle");
        chk("R12 host_irq off", {7'b0, host_irq}, 8'h00);

        // R12 edge between the two writes
        pulse_irq();
        bus_wr(4'h9, 8'h01);
        pulse_irq();
        bus_wr(4'h9, 8'h03);
        bus_rd(4'h8, 8'h01, "R12 edge between keeps");
        chk("R12 host_irq kept", {7'b0, host_irq}, 8'h01);

        // R12 edge in the same cycle as the re-enable write
        bus_wr(4'h9, 8'h01);
        @(negedge clk);
        hst_addr = 4'h9; hst_wdata = 8'h03; hst_wr = 1'b1; ctl_irq = 1'b1;
        @(negedge clk);
        hst_wr = 1'b0; ctl_irq = 1'b0;
        bus_rd(4'h8, 8'h01, "R12 coincident edge keeps");
        bus_wr(4'h9, 8'h01);
        bus_wr(4'h9, 8'h03);
        bus_rd(4'h8, 8'h00, "R12 clear again");

        // R11 / R12 edge while disabled, enabling alone does not clear
        bus_wr(4'h9, 8'h01);
        pulse_irq();
        chk("R11 disabled no irq", {7'b0, host_irq}, 8'h00);
        bus_wr(4'h9, 8'h03);
        chk("R12 enable alone keeps", {7'b0, host_irq}, 8'h01);

        // R1 reset midstream
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 rst host_irq", {7'b0, host_irq}, 8'h00);
        chk("R1 rst ctl_rst_n", {7'b0, ctl_rst_n}, 8'h00);
        chk("R1 rst cable", {7'b0, cable_utp}, 8'h00);
        rst_n = 1'b1;
        bus_rd(4'h8, 8'h00, "R1 reg0 after reset");
        bus_rd(4'h9, 8'h00, "R1 reg1 after reset");
        bus_rd(4'h0, 8'h4D, "R1 overlay mapped");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule